// File: doc/BRIEF.md
# Event Timestamp Capture Latch

This block holds the time at which a qualified timing-protocol event packet passed the port. It has two slots, one for the receive path and one for the transmit path. Each slot takes the free-running 64-bit time, a one-cycle event strobe that carries the packet's sequence identifier, and a 3-bit enable for its direction. An upstream classifier decides which packets qualify. This block only sees the resulting strobe.

A slot accepts the first qualifying strobe and keeps that capture until software releases it. Software polls the slot's status word until the valid flag is set. It then reads the low and high halves of the stored time. Finally it writes the status word with the valid bit set, which empties the slot so that the next event can be taken. All six words sit behind one small register port. Reads are combinational and writes take effect at the clock edge.

Top module: `evt_time_capture`

## Requirements
- R1: After reset, every readable word of both slots reads zero.
- R2: Address bit 2 picks the slot (0 receive, 1 transmit). Address bits 1:0 pick the word: 0 is status, 1 is stored time bits 31:0, 2 is stored time bits 63:32, and 3 always reads zero.
- R3: The status word carries the valid flag in bit 16 and the stored sequence identifier in bits 15:0. Every other bit reads zero.
- R4: A strobe is accepted when four conditions hold: the slot's enable is non-zero, the slot holds no capture, the slot has no capture waiting to become valid, and no clear write to that slot happens in the same cycle. On the accepting edge, the slot stores the time and sequence identifier present at that edge. The time words show the stored value right after that edge, but the valid flag reads 1 only after the following edge.
- R5: While a slot holds a capture, or has one waiting to become valid, further strobes leave all of its words unchanged.
- R6: With the slot's enable at 0, strobes are ignored.
- R7: A write of a value with bit 16 set to a slot's status word returns that slot to its reset state: valid clear, and stored time and identifier zero. A strobe arriving in the same cycle is not captured.
- R8: Writes with bit 16 clear, and writes to time words or to word 3, change nothing.
- R9: The two slots are independent. Strobes, enables and clears of one slot never change the other slot's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_time | input | 64 | Current free-running time |
| rx_evt | input | 1 | Receive qualified-event strobe |
| rx_seq | input | 16 | Receive packet sequence identifier |
| rx_en | input | 3 | Receive capture enable, 0 disables |
| tx_evt | input | 1 | Transmit qualified-event strobe |
| tx_seq | input | 16 | Transmit packet sequence identifier |
| tx_en | input | 3 | Transmit capture enable, 0 disables |
| csr_addr | input | 3 | Register word address |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |

## Verification
A clear write to a slot's status word and an event strobe for the same slot can arrive in the same cycle. A strobe can also land in the single cycle between capture and the valid flag rising. Directed cases put a strobe in the same cycle as a clear, and another strobe in that pending cycle. In both cases the slot must come out empty or holding the first capture. The random phase then mixes strobes, enables and clears on both slots at high rates, so these collisions recur many times. After every edge, all eight words are compared against a bench model written from the requirements.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2,
      SEL_NONE = 2'd3
   } word_sel_e;

   localparam int DIR_RX = 0;
   localparam int DIR_TX = 1;
endpackage

// File: rtl/evt_cap_slot.sv
module evt_cap_slot #(
   parameter int TIME_W = 64,
   parameter int SEQ_W  = 16,
   parameter int EN_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [SEQ_W-1:0]  seq_in,
   input  logic [EN_W-1:0]   en,
   input  logic [TIME_W-1:0] now,
   input  logic              clr,
   output logic              valid_q,
   output logic [SEQ_W-1:0]  seq_q,
   output logic [TIME_W-1:0] stamp_q
);
   logic pend_q;
   logic accept;

   assign accept = evt && (en != '0) && !valid_q && !pend_q && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         seq_q   <= '0;
         stamp_q <= '0;
      end else if (clr) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         seq_q   <= '0;
         stamp_q <= '0;
      end else if (accept) begin
         pend_q  <= 1'b1;
         seq_q   <= seq_in;
         stamp_q <= now;
      end else if (pend_q) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b1;
      end
   end

   // R4
   capture_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (pend_q && !valid_q && stamp_q == $past(now) && seq_q == $past(seq_in)));

   // R4
   pending_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr) |=> valid_q);

   // R5
   hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !clr) |=> (valid_q && $stable(stamp_q) && $stable(seq_q)));

   // R6
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0 && !pend_q && !valid_q) |=> !pend_q);

   // R7
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!valid_q && !pend_q && stamp_q == '0 && seq_q == '0));

   // R4
   never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_q && pend_q));
endmodule

// File: rtl/evt_cap_csr.sv
module evt_cap_csr
   import evt_cap_pkg::*;
#(
   parameter int N_DIR     = 2,
   parameter int TIME_W    = 64,
   parameter int SEQ_W     = 16,
   parameter int DATA_W    = 32,
   parameter int VALID_BIT = 16,
   parameter int DIR_W     = 1,
   parameter int ADDR_W    = 3
) (
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          wr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [N_DIR-1:0]              valid,
   input  logic [N_DIR-1:0][SEQ_W-1:0]   seq,
   input  logic [N_DIR-1:0][TIME_W-1:0]  stamp,
   output logic [N_DIR-1:0]              clr,
   output logic [DATA_W-1:0]             rdata
);
   logic [DIR_W-1:0] dir;
   word_sel_e        sel;
   logic             unused_wdata;

   assign dir          = addr[ADDR_W-1:2];
   assign sel          = word_sel_e'(addr[1:0]);
   assign unused_wdata = ^wdata;

   for (genvar g = 0; g < N_DIR; g++) begin : g_clr
      assign clr[g] = wr && (dir == DIR_W'(g)) && (sel == SEL_STAT) && wdata[VALID_BIT];
   end

   always_comb begin
      rdata = '0;
      if (int'(dir) < N_DIR) begin
         unique case (sel)
            SEL_STAT: begin
               rdata[SEQ_W-1:0] = seq[dir];
               rdata[VALID_BIT] = valid[dir];
            end
            SEL_LO:   rdata = stamp[dir][DATA_W-1:0];
            SEL_HI:   rdata = stamp[dir][TIME_W-1 -: DATA_W];
            default:  rdata = '0;
         endcase
      end
   end

   // R9
   always_comb begin
      clr_single_chk: assert ($onehot0(clr));
   end
endmodule

// File: rtl/evt_time_capture.sv
module evt_time_capture
   import evt_cap_pkg::*;
#(
   parameter int TIME_W    = 64,
   parameter int SEQ_W     = 16,
   parameter int EN_W      = 3,
   parameter int DATA_W    = 32,
   parameter int VALID_BIT = 16,
   localparam int N_DIR    = 2,
   localparam int DIR_W    = $clog2(N_DIR),
   localparam int ADDR_W   = DIR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] cur_time,
   input  logic              rx_evt,
   input  logic [SEQ_W-1:0]  rx_seq,
   input  logic [EN_W-1:0]   rx_en,
   input  logic              tx_evt,
   input  logic [SEQ_W-1:0]  tx_seq,
   input  logic [EN_W-1:0]   tx_en,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_wr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata
);
   if (TIME_W != 2 * DATA_W) begin : g_bad_time
      $error("time width must span exactly two data words");
   end
   if (SEQ_W > VALID_BIT) begin : g_bad_seq
      $error("sequence field overlaps the valid flag");
   end
   if (VALID_BIT >= DATA_W) begin : g_bad_flag
      $error("valid flag lies outside the data word");
   end

   logic [N_DIR-1:0]              evt_v;
   logic [N_DIR-1:0][SEQ_W-1:0]   seq_v;
   logic [N_DIR-1:0][EN_W-1:0]    en_v;
   logic [N_DIR-1:0]              clr_v;
   logic [N_DIR-1:0]              valid_v;
   logic [N_DIR-1:0][SEQ_W-1:0]   seqq_v;
   logic [N_DIR-1:0][TIME_W-1:0]  stamp_v;

   assign evt_v[DIR_RX] = rx_evt;
   assign evt_v[DIR_TX] = tx_evt;
   assign seq_v[DIR_RX] = rx_seq;
   assign seq_v[DIR_TX] = tx_seq;
   assign en_v[DIR_RX]  = rx_en;
   assign en_v[DIR_TX]  = tx_en;

   for (genvar g = 0; g < N_DIR; g++) begin : g_slot
      evt_cap_slot #(
         .TIME_W (TIME_W),
         .SEQ_W  (SEQ_W),
         .EN_W   (EN_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (evt_v[g]),
         .seq_in  (seq_v[g]),
         .en      (en_v[g]),
         .now     (cur_time),
         .clr     (clr_v[g]),
         .valid_q (valid_v[g]),
         .seq_q   (seqq_v[g]),
         .stamp_q (stamp_v[g])
      );
   end

   evt_cap_csr #(
      .N_DIR     (N_DIR),
      .TIME_W    (TIME_W),
      .SEQ_W     (SEQ_W),
      .DATA_W    (DATA_W),
      .VALID_BIT (VALID_BIT),
      .DIR_W     (DIR_W),
      .ADDR_W    (ADDR_W)
   ) u_csr (
      .addr  (csr_addr),
      .wr    (csr_wr),
      .wdata (csr_wdata),
      .valid (valid_v),
      .seq   (seqq_v),
      .stamp (stamp_v),
      .clr   (clr_v),
      .rdata (csr_rdata)
   );
endmodule

// File: tb/evt_time_capture_tb.sv
`timescale 1ns/100ps
module evt_time_capture_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cur_time = '0;
   logic        rx_evt = 1'b0, tx_evt = 1'b0;
   logic [15:0] rx_seq = '0, tx_seq = '0;
   logic [2:0]  rx_en = '0, tx_en = '0;
   logic [2:0]  csr_addr = '0;
   logic        csr_wr = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic        m_valid [2];
   logic        m_pend  [2];
   logic [63:0] m_ts    [2];
   logic [15:0] m_seq   [2];

   always #2.5 clk = ~clk;

   evt_time_capture u_dut (
      .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
      .rx_evt(rx_evt), .rx_seq(rx_seq), .rx_en(rx_en),
      .tx_evt(tx_evt), .tx_seq(tx_seq), .tx_en(tx_en),
      .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata)
   );

   function automatic logic [31:0] exp_word(int d, int w);
      logic [31:0] r = '0;
      case (w)
         0: begin r[15:0] = m_seq[d]; r[16] = m_valid[d]; end
         1: r = m_ts[d][31:0];
         2: r = m_ts[d][63:32];
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      for (int d = 0; d < 2; d++) begin
         for (int w = 0; w < 4; w++) begin
            csr_addr = 3'(d * 4 + w);
            #0.4;
            chk(req, csr_rdata, exp_word(d, w));
         end
      end
   endtask

   task automatic model_reset();
      for (int d = 0; d < 2; d++) begin
         m_valid[d] = 0; m_pend[d] = 0; m_ts[d] = '0; m_seq[d] = '0;
      end
   endtask

   // one edge: model update from driven inputs, then release strobes
   task automatic step();
      logic        ev [2];
      logic [15:0] sq [2];
      logic [2:0]  en [2];
      logic        clr, acc;
      ev[0] = rx_evt; ev[1] = tx_evt;
      sq[0] = rx_seq; sq[1] = tx_seq;
      en[0] = rx_en;  en[1] = tx_en;
      @(posedge clk);
      for (int d = 0; d < 2; d++) begin
         clr = csr_wr && (int'(csr_addr[2]) == d) && (csr_addr[1:0] == 2'd0) && csr_wdata[16];
         acc = ev[d] && (en[d] != 0) && !m_valid[d] && !m_pend[d] && !clr;
         if (clr) begin
            m_valid[d] = 0; m_pend[d] = 0; m_ts[d] = '0; m_seq[d] = '0;
         end else if (acc) begin
            m_pend[d] = 1; m_ts[d] = cur_time; m_seq[d] = sq[d];
         end else if (m_pend[d]) begin
            m_pend[d] = 0; m_valid[d] = 1;
         end
      end
      #1;
      rx_evt = 0; tx_evt = 0; csr_wr = 0; csr_wdata = '0;
   endtask

   task automatic clear_slot(int d, logic [31:0] val, logic [1:0] word);
      csr_wr = 1; csr_addr = {1'(d), word}; csr_wdata = val;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17_0C3E));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      // R1 reset state, R2 word layout
      check_all("R1");

      // R4 capture on receive with timing of valid flag
      rx_en = 3'd7; tx_en = 3'd0;
      cur_time = 64'h1234_5678_9ABC_DEF0;
      rx_evt = 1; rx_seq = 16'hBEEF;
      step();
      csr_addr = 3'd0; #0.4;
      chk("R4", csr_rdata, 32'h0000_BEEF);
      csr_addr = 3'd1; #0.4;
      chk("R4", csr_rdata, 32'h9ABC_DEF0);
      check_all("R4");
      // R5 strobe in the pending cycle is ignored
      cur_time = 64'hFFFF_0000_1111_2222;
      rx_evt = 1; rx_seq = 16'h0001;
      step();
      csr_addr = 3'd0; #0.4;
      chk("R3", csr_rdata, 32'h0001_BEEF);
      csr_addr = 3'd2; #0.4;
      chk("R2", csr_rdata, 32'h1234_5678);
      check_all("R5");
      // R5 strobe while valid ignored
      rx_evt = 1; rx_seq = 16'h0002; cur_time = 64'h5;
      step();
      check_all("R5");
      // R8 writes without bit 16, or to other words, change nothing
      clear_slot(0, 32'hFFFE_FFFF, 2'd0); step(); check_all("R8");
      clear_slot(0, 32'hFFFF_FFFF, 2'd1); step(); check_all("R8");
      clear_slot(0, 32'hFFFF_FFFF, 2'd3); step(); check_all("R8");
      // R9 clearing transmit leaves receive intact
      clear_slot(1, 32'h0001_0000, 2'd0); step(); check_all("R9");
      // R7 clear with a same-cycle strobe: slot empties, nothing captured
      clear_slot(0, 32'h0001_0000, 2'd0);
      rx_evt = 1; rx_seq = 16'h7777; cur_time = 64'hAAAA;
      step();
      csr_addr = 3'd0; #0.4;
      chk("R7", csr_rdata, 32'h0);
      check_all("R7");
      // R6 disabled receive ignores strobes
      rx_en = 3'd0; rx_evt = 1; rx_seq = 16'h4321;
      step(); step(); check_all("R6");
      // R9 transmit capture leaves receive empty
      tx_en = 3'd1; tx_evt = 1; tx_seq = 16'hCAFE; cur_time = 64'h0BAD_F00D_DEAD_0001;
      step(); step();
      csr_addr = 3'd4; #0.4;
      chk("R9", csr_rdata, 32'h0001_CAFE);
      check_all("R9");

      // random phase, mixed collisions
      for (int i = 0; i < 600; i++) begin
         cur_time = {$urandom, $urandom};
         rx_evt = ($urandom % 2) == 0;
         tx_evt = ($urandom % 2) == 0;
         rx_seq = 16'($urandom);
         tx_seq = 16'($urandom);
         if ($urandom % 8 == 0) rx_en = 3'($urandom);
         if ($urandom % 8 == 0) tx_en = 3'($urandom);
         if ($urandom % 3 == 0) begin
            csr_wr = 1;
            csr_addr = ($urandom % 4 == 0) ? 3'($urandom) : {1'($urandom), 2'd0};
            csr_wdata = $urandom;
            if ($urandom % 4 != 0) csr_wdata[16] = 1'b1;
         end
         step();
         check_all("R7");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule